// File: doc/BRIEF.md
# Queued Conversion Request Sequencer

This block feeds a multiplexed analog-to-digital converter with channel conversion requests taken from an ordered queue. Software pushes entries that hold a 3-bit channel number and a refill bit. The head entry is offered to the converter as a request. When the converter takes it, the entry leaves the queue. If its refill bit is set, the same entry goes back in at the tail, so a list written once is scanned again and again with no further software action.

Only one conversion is in flight at a time. The next request appears only after the converter reports that the current one is done. Each 12-bit result lands in a register owned by the converted channel, together with a valid flag. Software reads that register through a channel-addressed read port, and the read clears the flag. If a result overwrites a value that was never read, a sticky overrun bit is set.

A gate mode input picks one of two behaviours. In one mode, issuing is always allowed. In the other, issuing follows a level-sensitive gate input. A flush input empties the queue and leaves the results alone.

Top module: `conv_queue_seq`

## Requirements
- R1: A write pulse on `wr_valid_i` appends one entry, made of channel `wr_chan_i` (3 bits, values 0..7) and refill bit `wr_refill_i`, at the queue tail. Entries are offered in write order.
- R2: At most one conversion is outstanding. `req_valid_o` stays low from the cycle after `req_ack_i` is taken until the cycle after `conv_done_i` is seen, and requests follow strict queue order.
- R3: An accepted entry with refill=1 is re-appended at the tail in the same cycle it leaves the head. An accepted entry with refill=0 is removed for good. A written list therefore repeats its refill entries in order forever.
- R4: With `gate_mode_i`=0, requests are issued regardless of `gate_i`. With `gate_mode_i`=1, `req_valid_o` is high only while `gate_i` is 1.
- R5: On `conv_done_i`, the 12-bit `conv_result_i` (0..4095) is stored in the result register of the channel that was issued, and that register's valid flag is set.
- R6: `rd_data_o`, `rd_valid_o` and `rd_overrun_o` show the register selected by `rd_chan_i`. A cycle with `rd_en_i`=1 clears that register's valid and overrun flags, unless a new result for that channel arrives in the same cycle.
- R7: A result written to a register whose valid flag is still set also sets that register's overrun flag. The flag stays set until the register is read.
- R8: `full_o` is high when the queue holds DEPTH entries. A write that arrives while the queue is full and no entry leaves is dropped, and `wr_err_o` is high for the following cycle. No entry is added.
- R9: `flush_i` empties the queue (`empty_o`=1 the next cycle) and suppresses requests while it is high. It does not change any result register.
- R10: After reset, the queue is empty, `req_valid_o` is low, `full_o` is low, and every result register reads as invalid with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Queue write strobe |
| wr_chan_i | input | 3 | Channel of the written entry |
| wr_refill_i | input | 1 | Re-queue the entry after each issue |
| flush_i | input | 1 | Empty the queue |
| gate_mode_i | input | 1 | 0: always issue, 1: issue while gate_i is high |
| gate_i | input | 1 | Level gate for issuing |
| req_valid_o | output | 1 | Conversion request for the head entry |
| req_chan_o | output | 3 | Channel of the request |
| req_ack_i | input | 1 | Converter accepts the request |
| conv_done_i | input | 1 | Converter finished the outstanding conversion |
| conv_result_i | input | 12 | Conversion result |
| rd_en_i | input | 1 | Read strobe, clears the flags of the selected register |
| rd_chan_i | input | 3 | Result register select |
| rd_data_o | output | 12 | Selected result |
| rd_valid_o | output | 1 | Selected result is unread |
| rd_overrun_o | output | 1 | Selected result overwrote an unread one |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entry |
| wr_err_o | output | 1 | Previous write was dropped |

## Verification
The bench instantiates the block with DEPTH=8 and 12-bit results. With these values the full boundary is reached after eight writes, and every one of the eight channel registers can be addressed. A converter model in the bench uses a three-cycle latency, which opens a wide window in which a second, illegal request would be visible. Mixing refill and one-shot entries in one list lets a single scan show removal, re-append order and overrun on the channels that repeat.

// File: rtl/conv_queue_pkg.sv
package conv_queue_pkg;
  localparam int CHAN_W = 3;

  typedef struct packed {
    logic              refill;
    logic [CHAN_W-1:0] chan;
  } q_entry_t;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo
  import conv_queue_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     sw_push_i,
  input  q_entry_t sw_entry_i,
  input  logic     pop_i,
  output q_entry_t head_o,
  output logic     empty_o,
  output logic     full_o,
  output logic     wr_err_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  q_entry_t        mem_q [DEPTH];
  logic [PW-1:0]   rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]   count_q;
  logic            re_push, sw_ok;
  logic [CW:0]     count_mid;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] n);
    logic [PW+1:0] s;
    s = (PW+2)'(p) + (PW+2)'(n);
    if (s >= (PW+2)'(DEPTH)) s = s - (PW+2)'(DEPTH);
    return s[PW-1:0];
  endfunction

  assign head_o    = mem_q[rd_ptr_q];
  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CW'(DEPTH));
  assign re_push   = pop_i & head_o.refill;
  assign count_mid = {1'b0, count_q} - (CW+1)'(pop_i) + (CW+1)'(re_push);
  assign sw_ok     = sw_push_i & ~flush_i & (count_mid < (CW+1)'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (re_push) mem_q[wr_ptr_q] <= head_o;
    if (sw_ok)   mem_q[re_push ? adv(wr_ptr_q, 2'd1) : wr_ptr_q] <= sw_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      wr_err_o <= 1'b0;
    end else begin
      wr_err_o <= sw_push_i & ~flush_i & ~sw_ok;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
        count_q  <= '0;
      end else begin
        rd_ptr_q <= adv(rd_ptr_q, {1'b0, pop_i});
        wr_ptr_q <= adv(wr_ptr_q, 2'(re_push) + 2'(sw_ok));
        count_q  <= CW'(count_mid + (CW+1)'(sw_ok));
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_drop_when_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && sw_push_i && !pop_i && !flush_i) |=> (wr_err_o && full_o));
  p_refill_keeps_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_push && !sw_push_i && !flush_i) |=> count_q == $past(count_q));
  p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/cq_issue.sv
module cq_issue
  import conv_queue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_mode_i,
  input  logic              gate_i,
  input  logic              flush_i,
  input  logic              empty_i,
  input  logic [CHAN_W-1:0] head_chan_i,
  input  logic              req_ack_i,
  input  logic              conv_done_i,
  output logic              req_valid_o,
  output logic [CHAN_W-1:0] req_chan_o,
  output logic              pop_o,
  output logic              res_we_o,
  output logic [CHAN_W-1:0] res_chan_o
);
  logic              busy_q;
  logic [CHAN_W-1:0] cur_chan_q;
  logic              gate_ok;

  assign gate_ok     = gate_mode_i ? gate_i : 1'b1;
  assign req_valid_o = ~busy_q & ~empty_i & ~flush_i & gate_ok;
  assign req_chan_o  = head_chan_i;
  assign pop_o       = req_valid_o & req_ack_i;
  assign res_we_o    = busy_q & conv_done_i;
  assign res_chan_o  = cur_chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cur_chan_q <= '0;
    end else if (pop_o) begin
      busy_q     <= 1'b1;
      cur_chan_q <= head_chan_i;
    end else if (res_we_o) begin
      busy_q     <= 1'b0;
    end
  end

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !req_valid_o);
  p_wait_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_o && $past(pop_o) && !conv_done_i) |=> !req_valid_o);
  p_gate_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_mode_i && !gate_i) |-> !req_valid_o);
endmodule

// File: rtl/cq_result_bank.sv
module cq_result_bank
  import conv_queue_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic [RES_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [CHAN_W-1:0] rd_chan_i,
  output logic [RES_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_overrun_o
);
  localparam int NCH = 1 << CHAN_W;

  logic [RES_W-1:0] data_q [NCH];
  logic [NCH-1:0]   vld_q, ovr_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_w, hit_r;
    assign hit_w = we_i & (wr_chan_i == CHAN_W'(c));
    assign hit_r = rd_en_i & (rd_chan_i == CHAN_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[c] <= '0;
        vld_q[c]  <= 1'b0;
        ovr_q[c]  <= 1'b0;
      end else if (hit_w) begin
        data_q[c] <= wr_data_i;
        vld_q[c]  <= 1'b1;
        ovr_q[c]  <= (ovr_q[c] | vld_q[c]) & ~hit_r;
      end else if (hit_r) begin
        vld_q[c]  <= 1'b0;
        ovr_q[c]  <= 1'b0;
      end
    end
  end

  assign rd_data_o    = data_q[rd_chan_i];
  assign rd_valid_o   = vld_q[rd_chan_i];
  assign rd_overrun_o = ovr_q[rd_chan_i];

  p_valid_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(wr_chan_i)]);
  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !(we_i && wr_chan_i == rd_chan_i)) |=> !vld_q[$past(rd_chan_i)]);
  p_overrun_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rd_valid_o && wr_chan_i == rd_chan_i && !rd_en_i) |=> ovr_q[$past(wr_chan_i)]);
endmodule

// File: rtl/conv_queue_seq.sv
module conv_queue_seq
  import conv_queue_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic              wr_refill_i,
  input  logic              flush_i,
  input  logic              gate_mode_i,
  input  logic              gate_i,
  output logic              req_valid_o,
  output logic [CHAN_W-1:0] req_chan_o,
  input  logic              req_ack_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  input  logic              rd_en_i,
  input  logic [CHAN_W-1:0] rd_chan_i,
  output logic [RES_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_overrun_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              wr_err_o
);
  q_entry_t          sw_entry, head;
  logic              pop, res_we;
  logic [CHAN_W-1:0] res_chan;

  assign sw_entry = '{refill: wr_refill_i, chan: wr_chan_i};

  cq_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni, .flush_i,
    .sw_push_i (wr_valid_i),
    .sw_entry_i(sw_entry),
    .pop_i     (pop),
    .head_o    (head),
    .empty_o, .full_o, .wr_err_o
  );

  cq_issue i_issue (
    .clk_i, .rst_ni, .gate_mode_i, .gate_i, .flush_i,
    .empty_i    (empty_o),
    .head_chan_i(head.chan),
    .req_ack_i, .conv_done_i, .req_valid_o, .req_chan_o,
    .pop_o      (pop),
    .res_we_o   (res_we),
    .res_chan_o (res_chan)
  );

  cq_result_bank #(.RES_W(RES_W)) i_bank (
    .clk_i, .rst_ni,
    .we_i     (res_we),
    .wr_chan_i(res_chan),
    .wr_data_i(conv_result_i),
    .rd_en_i, .rd_chan_i, .rd_data_o, .rd_valid_o, .rd_overrun_o
  );
endmodule

// File: tb/test_conv_queue_seq.sv
module test_conv_queue_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LAT = 3;
  localparam int NTBL = 6;
  // table: {refill, chan}
  localparam logic [3:0] TBL [NTBL] = '{4'h2, 4'hD, 4'h0, 4'hF, 4'h3, 4'h9};
  localparam logic [2:0] RFL [3] = '{3'd5, 3'd7, 3'd1};

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_refill = 0, flush = 0, gate_mode = 1, gate = 0;
  logic [2:0] wr_chan = 0, rd_chan = 0, req_chan;
  logic req_valid, ack, done, rd_en = 0, rd_valid, rd_ovr, full, empty, wr_err;
  logic [11:0] result, rd_data;

  int checks = 0, errors = 0;
  logic model_busy;
  int cnt, n_issued, viol;
  logic [2:0] m_chan;
  logic [11:0] pend;
  logic [2:0] issue_log [64];
  logic [11:0] exp_res [8];
  int conv_cnt [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_queue_seq #(.DEPTH(DEPTH), .RES_W(12)) i_conv_queue_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_chan_i(wr_chan),
    .wr_refill_i(wr_refill), .flush_i(flush), .gate_mode_i(gate_mode), .gate_i(gate),
    .req_valid_o(req_valid), .req_chan_o(req_chan), .req_ack_i(ack),
    .conv_done_i(done), .conv_result_i(result), .rd_en_i(rd_en), .rd_chan_i(rd_chan),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_overrun_o(rd_ovr),
    .full_o(full), .empty_o(empty), .wr_err_o(wr_err)
  );

  // converter model
  assign ack = req_valid & ~model_busy;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_busy <= 0; cnt <= 0; done <= 0; result <= 0; n_issued <= 0; viol <= 0;
      m_chan <= 0; pend <= 0;
      for (int i = 0; i < 8; i++) begin exp_res[i] <= 0; conv_cnt[i] <= 0; end
    end else begin
      done <= 0;
      if (req_valid && (model_busy || done)) viol <= viol + 1;
      if (ack) begin
        model_busy <= 1; cnt <= LAT; m_chan <= req_chan;
        pend <= 12'((int'(req_chan) * 411 + n_issued * 37) % 4096);
        if (n_issued < 64) issue_log[n_issued] <= req_chan;
        n_issued <= n_issued + 1;
      end else if (model_busy) begin
        if (cnt == 0) begin
          done <= 1; result <= pend; model_busy <= 0;
          exp_res[m_chan] <= pend; conv_cnt[m_chan] <= conv_cnt[m_chan] + 1;
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ch, input logic rf);
    @(negedge clk); wr_valid = 1; wr_chan = ch; wr_refill = rf;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic wait_issues(input int n);
    for (int i = 0; i < 2000 && n_issued < n; i++) @(negedge clk);
  endtask

  task automatic stop_and_settle();
    @(negedge clk); gate_mode = 1; gate = 0;
    repeat (LAT + 6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 empty", 32'(empty), 1);
    chk("R10 full", 32'(full), 0);
    chk("R10 req_valid", 32'(req_valid), 0);
    rd_chan = 3'd4; #1;
    chk("R10 rd_valid", 32'(rd_valid), 0);
    @(negedge clk); rst_n = 1;

    // table walk: write list with gate closed
    for (int k = 0; k < NTBL; k++) begin
      wr(TBL[k][2:0], TBL[k][3]);
      #1; chk("R4 gate closed blocks", 32'(req_valid), 0);
    end
    chk("R1 not empty", 32'(empty), 0);

    @(negedge clk); gate = 1;
    wait_issues(14);
    stop_and_settle();
    chk("R2 single outstanding", 32'(viol), 0);
    for (int k = 0; k < 64 && k < n_issued; k++) begin
      logic [2:0] e;
      e = (k < NTBL) ? TBL[k][2:0] : RFL[(k - NTBL) % 3];
      chk(k < NTBL ? "R1 issue order" : "R3 refill order", 32'(issue_log[k]), 32'(e));
    end

    // flush keeps results
    @(negedge clk); flush = 1; gate = 1;
    #1; chk("R9 no request during flush", 32'(req_valid), 0);
    @(negedge clk); flush = 0; gate = 0;
    #1; chk("R9 empty after flush", 32'(empty), 1);

    for (int c = 0; c < 8; c++) begin
      @(negedge clk); rd_chan = 3'(c); #1;
      chk("R5 valid", 32'(rd_valid), 32'(conv_cnt[c] > 0));
      if (conv_cnt[c] > 0) chk("R5 data", 32'(rd_data), 32'(exp_res[c]));
      chk("R7 overrun", 32'(rd_ovr), 32'(conv_cnt[c] > 1));
      rd_en = 1;
      @(negedge clk); rd_en = 0; #1;
      chk("R6 read clears valid", 32'(rd_valid), 0);
      chk("R6 read clears overrun", 32'(rd_ovr), 0);
    end

    // always mode ignores gate
    base = n_issued;
    @(negedge clk); gate_mode = 0; gate = 0;
    wr(3'd6, 1'b0);
    wait_issues(base + 1);
    chk("R4 always mode issues", 32'(n_issued), 32'(base + 1));
    repeat (LAT + 4) @(negedge clk);
    rd_chan = 3'd6; #1;
    chk("R5 ch6 valid", 32'(rd_valid), 1);
    chk("R5 ch6 data", 32'(rd_data), 32'(exp_res[6]));
    chk("R3 one-shot removed", 32'(empty), 1);

    // full boundary
    @(negedge clk); gate_mode = 1; gate = 0;
    base = n_issued;
    for (int c = 0; c < DEPTH; c++) wr(3'(c), 1'b0);
    #1; chk("R8 full", 32'(full), 1);
    @(negedge clk); wr_valid = 1; wr_chan = 3'd4; wr_refill = 1;
    @(negedge clk); #1; chk("R8 wr_err", 32'(wr_err), 1);
    wr_valid = 0;
    @(negedge clk); #1; chk("R8 wr_err one cycle", 32'(wr_err), 0);
    chk("R8 still full", 32'(full), 1);
    gate = 1;
    wait_issues(base + DEPTH);
    repeat (4 * (LAT + 4)) @(negedge clk);
    chk("R8 dropped write not issued", 32'(n_issued), 32'(base + DEPTH));
    for (int c = 0; c < DEPTH; c++)
      chk("R1 fill order", 32'(issue_log[base + c]), 32'(c));
    chk("R8 empty at end", 32'(empty), 1);
    chk("R2 single outstanding end", 32'(viol), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule